// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every data beat of a synchronous DRAM burst. A one-cycle start pulse captures an 8-bit start column, a length code and an ordering mode. From the following cycle the block presents one column per clock, together with a valid flag, the beat number and a flag marking the final beat of a fixed-length burst.

Fixed lengths of 1, 2, 4 and 8 keep every beat inside the aligned block of that size that holds the start column. In counting order the low bits step upward and wrap with no carry into the upper bits. In the exclusive-or order the low bits of the start column are XORed with the beat number. The full-page length walks through all 256 columns with wrap-around and runs until a stop request ends it.

A new start at any time abandons the current burst and begins a fresh one of full length. A controller drives the block alongside its read and write commands. Issuing commands and moving data are not part of this block.

Top module: `sdram_col_burst`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `valid` and `last` are 0 and `beat` is 0. Reset is synchronous and active high.
- R2: A start sampled high at a clock edge makes the next cycle show `valid`=1, `beat`=0 and `col` equal to the sampled start column. The length code and the ordering mode are captured at that start, and later changes to them have no effect on the running burst.
- R3: The length code is `len_sel`: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 4 to 7 give full page. Within a burst, `beat` rises by one each cycle. A fixed burst shows exactly its length in beats, and `valid` falls in the cycle after the last beat.
- R4: With `interleave`=0 and a fixed length BL, beat k shows the upper bits of the start column unchanged and the low log2(BL) bits equal to (start low bits + k) mod BL.
- R5: With `interleave`=1 and a fixed length BL, beat k shows the start column with its low log2(BL) bits XORed with k.
- R6: `last` is 1 only on the final beat of a fixed-length burst. At length 1 it is 1 on the first beat, and it is never 1 in full-page mode.
- R7: In full-page mode, beat k shows (start + k) mod 256. The `interleave` input is ignored in this mode.
- R8: A `stop` sampled high during a burst, without a start in the same cycle, makes `valid` 0 in the next cycle. A `stop` while idle has no effect.
- R9: A start during a burst, including on its last beat or together with `stop`, begins the new burst in the next cycle with its full length. Start takes priority over stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 8 | First column of the burst |
| len_sel | input | 3 | Burst length code (see R3) |
| interleave | input | 1 | 1 selects the exclusive-or order, 0 the counting order |
| stop | input | 1 | End the running burst |
| col | output | 8 | Column for the current beat |
| valid | output | 1 | `col` holds a burst beat |
| beat | output | 8 | Index of the current beat |
| last | output | 1 | Final beat of a fixed-length burst |

## Verification
Two pairs of functions can fall in the same cycle. A new start can coincide with the end of a burst, either on its last beat or together with a stop request. The bench provokes the first by raising start on the cycle that shows the final beat of a two-beat burst. It provokes the second by raising start and stop together in the middle of a full-page burst. In both cases the next cycle must show beat 0 of the new burst with `valid` still high, and the new burst must then run its full length.

// File: rtl/sdram_col_burst.sv
module sdram_col_burst #(
  parameter int COL_W     = 8,
  parameter int LEN_W     = 3,
  parameter int FULL_CODE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [LEN_W-1:0] len_sel,
  input  logic             interleave,
  input  logic             stop,
  output logic [COL_W-1:0] col,
  output logic             valid,
  output logic [COL_W-1:0] beat,
  output logic             last
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(FULL_CODE);

  logic [COL_W-1:0] base_q, mask_q, beat_q;
  logic             valid_q, full_q, il_q;

  logic             full_d;
  logic [COL_W:0]   size_d;
  logic [COL_W-1:0] mask_d;
  logic [COL_W-1:0] col_seq, col_il;

  assign full_d = len_sel >= FULL_LEN;
  assign size_d = (COL_W+1)'(1) << len_sel;
  assign mask_d = full_d ? '1 : (size_d[COL_W-1:0] - COL_W'(1));

  assign col_seq = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
  assign col_il  = base_q ^ (beat_q & mask_q);

  assign col   = il_q ? col_il : col_seq;
  assign valid = valid_q;
  assign beat  = beat_q;
  assign last  = valid_q & ~full_q & (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      il_q    <= 1'b0;
    end else if (start) begin
      valid_q <= 1'b1;
      beat_q  <= '0;
      base_q  <= start_col;
      mask_q  <= mask_d;
      full_q  <= full_d;
      il_q    <= interleave & ~full_d;
    end else if (valid_q) begin
      if (stop || last) begin
        valid_q <= 1'b0;
        beat_q  <= '0;
      end else begin
        beat_q  <= beat_q + COL_W'(1);
      end
    end
  end

endmodule

// File: rtl/sdram_col_burst_chk.sv
module sdram_col_burst_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic [COL_W-1:0] col,
  input logic             valid,
  input logic [COL_W-1:0] beat,
  input logic             last
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!valid && !last && beat == '0));

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (valid && beat == '0 && col == $past(start_col)));

  assert_beat_steps_R3: assert property (@(posedge clk) disable iff (rst)
    (valid && !last && !start && !stop) |=> (valid && beat == COL_W'($past(beat) + COL_W'(1))));

  assert_last_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
    last |-> valid);

  assert_end_drops_valid_R8: assert property (@(posedge clk) disable iff (rst)
    ((last || stop) && !start) |=> !valid);

  assert_start_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (start && stop) |=> valid);

endmodule

bind sdram_col_burst sdram_col_burst_chk #(.COL_W(COL_W)) i_chk (
  .clk(clk), .rst(rst), .start(start), .start_col(start_col), .stop(stop),
  .col(col), .valid(valid), .beat(beat), .last(last)
);

// File: tb/test_sdram_col_burst.sv
module test_sdram_col_burst;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;
  localparam int NVEC = 8;
  // {start_col[19:12], len_sel[11:9], interleave[8], beats[7:0]}
  localparam logic [19:0] VECS [NVEC] = '{
    {8'h00, 3'd0, 1'b0, 8'd1},
    {8'h37, 3'd1, 1'b1, 8'd2},
    {8'h5E, 3'd2, 1'b0, 8'd4},
    {8'hFF, 3'd2, 1'b1, 8'd4},
    {8'h5D, 3'd3, 1'b1, 8'd8},
    {8'hA6, 3'd3, 1'b0, 8'd8},
    {8'hFD, 3'd4, 1'b0, 8'd6},
    {8'h7A, 3'd7, 1'b1, 8'd4}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_sel = '0;
  logic       interleave = 1'b0;
  logic       stop = 1'b0;
  logic [7:0] col, beat;
  logic       valid, last;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  sdram_col_burst i_sdram_col_burst (
    .clk(clk), .rst(rst), .start(start), .start_col(start_col),
    .len_sel(len_sel), .interleave(interleave), .stop(stop),
    .col(col), .valid(valid), .beat(beat), .last(last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WDOG_CYCLES) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(int sc, int ln, bit il, int k);
    int bl, lo, hi;
    if (ln >= 4) return (sc + k) % 256;
    bl = 1 << ln;
    lo = sc % bl;
    hi = sc - lo;
    if (il) return hi + (lo ^ (k % bl));
    return hi + ((lo + k) % bl);
  endfunction

  task automatic start_at(int sc, int ln, bit il, bit st);
    start = 1'b1; start_col = 8'(sc); len_sel = 3'(ln); interleave = il; stop = st;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
  endtask

  task automatic beat_chk(int sc, int ln, bit il, int k);
    string rq;
    rq = (ln >= 4) ? "R7 col" : (il ? "R5 col" : "R4 col");
    chk("R2 valid", int'(valid), 1);
    chk("R3 beat", int'(beat), k % 256);
    chk(rq, int'(col), exp_col(sc, ln, il, k));
    chk("R6 last", int'(last), int'(ln < 4 && k == (1 << ln) - 1));
  endtask

  task automatic run(int sc, int ln, bit il, int n);
    start_at(sc, ln, il, 1'b0);
    for (int k = 0; k < n; k++) begin
      beat_chk(sc, ln, il, k);
      if (k == n - 1 && ln >= 4) stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
    end
    chk((ln >= 4) ? "R8 stop ends" : "R3 burst ends", int'(valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(valid), 0);
    chk("R1 last in reset", int'(last), 0);
    chk("R1 beat in reset", int'(beat), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", int'(valid), 0);

    for (int v = 0; v < NVEC; v++)
      run(int'(VECS[v][19:12]), int'(VECS[v][11:9]), VECS[v][8], int'(VECS[v][7:0]));

    // R2: length and ordering captured at start only
    start_at(8'h13, 2, 1'b0, 1'b0);
    len_sel = 3'd0; interleave = 1'b1;
    for (int k = 0; k < 4; k++) begin
      beat_chk(8'h13, 2, 1'b0, k);
      @(negedge clk);
    end
    chk("R2 captured length ends", int'(valid), 0);

    // R8: stop while idle has no effect
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 idle stop", int'(valid), 0);

    // R8: stop cuts a fixed burst
    start_at(8'h20, 3, 1'b0, 1'b0);
    beat_chk(8'h20, 3, 1'b0, 0);
    @(negedge clk);
    beat_chk(8'h20, 3, 1'b0, 1);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 stop fixed", int'(valid), 0);

    // R9: restart mid-burst with new column and order
    start_at(8'h40, 3, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      beat_chk(8'h40, 3, 1'b0, k);
      if (k < 2) @(negedge clk);
    end
    start_at(8'h85, 3, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      beat_chk(8'h85, 3, 1'b1, k);
      @(negedge clk);
    end
    chk("R9 restarted full length", int'(valid), 0);

    // R9: start together with stop in full-page mode
    start_at(8'h10, 5, 1'b0, 1'b0);
    beat_chk(8'h10, 5, 1'b0, 0);
    @(negedge clk);
    beat_chk(8'h10, 5, 1'b0, 1);
    start_at(8'h2B, 1, 1'b0, 1'b1);
    beat_chk(8'h2B, 1, 1'b0, 0);
    @(negedge clk);
    beat_chk(8'h2B, 1, 1'b0, 1);
    // R9: start on the final beat runs back to back
    start_at(8'hC3, 0, 1'b0, 1'b0);
    beat_chk(8'hC3, 0, 1'b0, 0);
    @(negedge clk);
    chk("R9 single after back-to-back", int'(valid), 0);

    // R1: reset mid-burst
    start_at(8'h66, 3, 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid-burst valid", int'(valid), 0);
    chk("R1 reset mid-burst beat", int'(beat), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 stays idle", int'(valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule